// File: doc/BRIEF.md
# Synchronous Transfer Clock Divider

This block generates the timing strobes for a parallel SCSI synchronous data phase and for the controller's asynchronous core logic, all from one source clock. The strobes are single-cycle clock enables in the `clk_i` domain. They are not gated clocks, so every consumer stays on one clock tree.

`clk_i` runs at twice the nominal input rate. With the doubler off, a source tick comes every second `clk_i` cycle. With the doubler on, a tick comes every cycle. Each prescaler divides the tick stream by 1, 1.5, 2 or 3. The synchronous prescaler output then goes through a period divider of 4 to 11, which gives the send and receive strobes. The core prescaler drives the core-logic strobe on its own.

A rate guard compares the selected rates against limits set by parameters. When a limit is exceeded, it latches an error flag and silences every strobe.

Top module: `xfer_clkdiv`

## Requirements
- R1: The synchronous prescaler code divides the source tick rate by 1 for 001, by 1.5 for 010, by 2 for 011 and by 3 for 100. Codes 000 and 101 to 111 also divide by 3.
- R2: At the 1.5 ratio, the gaps between successive prescaler enables alternate between 1 and 2 source ticks, so there are exactly 2 enables every 3 ticks.
- R3: The period code value k (0 to 7) divides the synchronous enable stream by 4+k, and `send_en_o` pulses once per period.
- R4: The core prescaler uses the R1 encoding independently, and its output appears on `core_en_o`.
- R5: With `dbl_en_i` low, a source tick occurs every second `clk_i` cycle. With it high, a tick occurs every cycle.
- R6: Within a period of P synchronous enables counted 0 to P-1, `recv_en_o` pulses at count P/2-1 (rounded down) and `send_en_o` pulses at count P-1. Each pulse is one `clk_i` cycle wide.
- R7: `sync_err_o` sets when source rate / synchronous divisor exceeds SYNC_MAX_KHZ. `core_err_o` sets when source rate / core divisor exceeds CORE_MAX_KHZ. The source rate is IN_FREQ_KHZ, doubled when `dbl_en_i` is high. Both flags are sticky until reset. While either flag is set, or either rate is currently exceeded, all four enables stay low.
- R8: A new prescaler code takes effect only after an enable that leaves the prescaler's fractional phase at zero. A new period code takes effect only when `send_en_o` pulses. The period or gap in progress always completes with the old setting.
- R9: While `rst_ni` is low, all enables and both error flags are low. Reset selects divide by 3 for both prescalers and 4 for the period divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock, twice the nominal input rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbl_en_i | input | 1 | Doubler select: 1 = tick every cycle |
| sync_code_i | input | 3 | Synchronous prescaler code |
| per_code_i | input | 3 | Transfer period code (divisor 4+code) |
| core_code_i | input | 3 | Core prescaler code |
| sync_en_o | output | 1 | Synchronous core rate enable |
| send_en_o | output | 1 | Send strobe, end of period |
| recv_en_o | output | 1 | Receive strobe, mid period |
| core_en_o | output | 1 | Asynchronous core logic enable |
| sync_err_o | output | 1 | Sticky synchronous rate violation |
| core_err_o | output | 1 | Sticky core rate violation |

## Verification
The hardest case to reach from the ports is a code change that arrives in the middle of a period. It shows up only as the length of one particular gap. To create it, the stimulus waits for a send or synchronous strobe and writes the new code on the very next cycle, which is well inside the running period. It then measures two gaps: the first must have the old length and the second the new one. The 1.5 ratio is checked in the same way, by timing consecutive enables. Rate counts are taken over windows that span a whole number of periods, so every expected count is an exact integer.

// File: rtl/xfer_clk_pkg.sv
package xfer_clk_pkg;
  localparam int unsigned CODE_W = 3;
  typedef logic [CODE_W-1:0] code_t;

  localparam code_t PRE_RST_CODE = 3'b100;
  localparam code_t PER_RST_CODE = 3'b000;

  // prescaler divisor in half units: 2 = /1, 3 = /1.5, 4 = /2, 6 = /3
  function automatic logic [2:0] pre_half_div(input code_t c);
    case (c)
      3'b001:  return 3'd2;
      3'b010:  return 3'd3;
      3'b011:  return 3'd4;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/xfer_src_tick.sv
module xfer_src_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbl_i,
  output logic tick_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign tick_o = dbl_i | ph_q;

  p_tick_alt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbl_i && tick_o) |=> (!tick_o || dbl_i));
endmodule

// File: rtl/xfer_prescaler.sv
module xfer_prescaler
  import xfer_clk_pkg::*;
#(
  parameter code_t RST_CODE = PRE_RST_CODE
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  code_t code_i,
  output logic  en_o
);
  localparam int unsigned ACC_W = 3;

  code_t            cur_q;
  logic [ACC_W-1:0] acc_q, d2, sum, rem;
  logic             hit, bnd;

  // accumulate 2 half units per tick, fire when a full divisor is reached
  always_comb begin
    d2  = pre_half_div(cur_q);
    sum = acc_q + ACC_W'(2);
    hit = tick_i && (sum >= d2);
    rem = hit ? (sum - d2) : sum;
    bnd = hit && (rem == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= RST_CODE;
      acc_q <= '0;
    end else if (tick_i) begin
      acc_q <= rem;
      if (bnd) cur_q <= code_i;
    end
  end

  assign en_o = hit;

  p_acc_lt_div_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < d2);
  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |=> $stable(cur_q));
  p_no_back2back_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && d2 >= 3'd4 && code_i == cur_q) |=> !en_o);
endmodule

// File: rtl/xfer_period_div.sv
module xfer_period_div
  import xfer_clk_pkg::*;
#(
  parameter int unsigned PER_BASE = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  code_t code_i,
  output logic  send_o,
  output logic  recv_o
);
  localparam int unsigned PER_MAX = PER_BASE + (2 ** CODE_W) - 1;
  localparam int unsigned CNT_W   = $clog2(PER_MAX + 1);

  code_t            cur_q;
  logic [CNT_W-1:0] cnt_q, per, mid;
  logic             last;

  always_comb begin
    per  = CNT_W'(PER_BASE) + CNT_W'(cur_q);
    mid  = (per >> 1) - CNT_W'(1);
    last = step_i && (cnt_q == per - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= PER_RST_CODE;
      cnt_q <= '0;
    end else if (step_i) begin
      if (last) begin
        cnt_q <= '0;
        cur_q <= code_i;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign send_o = last;
  assign recv_o = step_i && (cnt_q == mid);

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < per);
  p_send_recv_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(send_o && recv_o));
  p_send_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_o |=> !send_o);
  p_per_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !send_o |=> $stable(cur_q));
endmodule

// File: rtl/xfer_rate_guard.sv
module xfer_rate_guard
  import xfer_clk_pkg::*;
#(
  parameter int unsigned IN_FREQ_KHZ  = 40000,
  parameter int unsigned SYNC_MAX_KHZ = 80000,
  parameter int unsigned CORE_MAX_KHZ = 25000
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dbl_i,
  input  code_t sync_code_i,
  input  code_t core_code_i,
  output logic  sync_err_o,
  output logic  core_err_o,
  output logic  halt_o
);
  longint unsigned src_khz;
  logic            sync_bad, core_bad;
  logic            sync_err_q, core_err_q;

  // rate > max  <=>  2*src > max * half_divisor
  always_comb begin
    src_khz  = dbl_i ? 64'(IN_FREQ_KHZ) * 64'd2 : 64'(IN_FREQ_KHZ);
    sync_bad = (src_khz * 64'd2) > (64'(SYNC_MAX_KHZ) * 64'(pre_half_div(sync_code_i)));
    core_bad = (src_khz * 64'd2) > (64'(CORE_MAX_KHZ) * 64'(pre_half_div(core_code_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_err_q <= 1'b0;
      core_err_q <= 1'b0;
    end else begin
      sync_err_q <= sync_err_q | sync_bad;
      core_err_q <= core_err_q | core_bad;
    end
  end

  assign sync_err_o = sync_err_q;
  assign core_err_o = core_err_q;
  assign halt_o     = sync_err_q | core_err_q | sync_bad | core_bad;

  p_sync_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_q |=> sync_err_q);
  p_core_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_err_q |=> core_err_q);
endmodule

// File: rtl/xfer_clkdiv.sv
module xfer_clkdiv
  import xfer_clk_pkg::*;
#(
  parameter int unsigned IN_FREQ_KHZ  = 40000,
  parameter int unsigned SYNC_MAX_KHZ = 80000,
  parameter int unsigned CORE_MAX_KHZ = 25000,
  parameter int unsigned PER_BASE     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dbl_en_i,
  input  logic [2:0] sync_code_i,
  input  logic [2:0] per_code_i,
  input  logic [2:0] core_code_i,
  output logic       sync_en_o,
  output logic       send_en_o,
  output logic       recv_en_o,
  output logic       core_en_o,
  output logic       sync_err_o,
  output logic       core_err_o
);
  logic tick, sync_raw, core_raw, send_raw, recv_raw, halt;

  xfer_src_tick u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .dbl_i (dbl_en_i),
    .tick_o(tick)
  );

  xfer_prescaler #(.RST_CODE(PRE_RST_CODE)) u_sync_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .code_i(sync_code_i),
    .en_o  (sync_raw)
  );

  xfer_prescaler #(.RST_CODE(PRE_RST_CODE)) u_core_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .code_i(core_code_i),
    .en_o  (core_raw)
  );

  xfer_period_div #(.PER_BASE(PER_BASE)) u_per (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(sync_raw),
    .code_i(per_code_i),
    .send_o(send_raw),
    .recv_o(recv_raw)
  );

  xfer_rate_guard #(
    .IN_FREQ_KHZ (IN_FREQ_KHZ),
    .SYNC_MAX_KHZ(SYNC_MAX_KHZ),
    .CORE_MAX_KHZ(CORE_MAX_KHZ)
  ) u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbl_i      (dbl_en_i),
    .sync_code_i(sync_code_i),
    .core_code_i(core_code_i),
    .sync_err_o (sync_err_o),
    .core_err_o (core_err_o),
    .halt_o     (halt)
  );

  assign sync_en_o = sync_raw & ~halt;
  assign core_en_o = core_raw & ~halt;
  assign send_en_o = send_raw & ~halt;
  assign recv_en_o = recv_raw & ~halt;

  p_gate_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_o || core_err_o) |-> !(sync_en_o || core_en_o || send_en_o || recv_en_o));
  p_send_on_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_en_o |-> sync_en_o);
endmodule

// File: tb/sim_xfer_clkdiv.sv
module sim_xfer_clkdiv;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dbl = 1'b0;
  logic [2:0] s_code = 3'b100, p_code = 3'b000, c_code = 3'b100;
  logic       sync_en, send_en, recv_en, core_en, sync_err, core_err;

  int n_run = 0, n_fail = 0, cyc = 0;
  int cnt[4];
  logic win = 1'b0, win_prev = 1'b0;
  event win_done;
  int    exp_q[$];
  int    kind_q[$];
  string req_q[$];

  always #4 clk = ~clk;  // 125 MHz

  xfer_clkdiv #(
    .IN_FREQ_KHZ (50000),
    .SYNC_MAX_KHZ(80000),
    .CORE_MAX_KHZ(40000),
    .PER_BASE    (4)
  ) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dbl_en_i   (dbl),
    .sync_code_i(s_code),
    .per_code_i (p_code),
    .core_code_i(c_code),
    .sync_en_o  (sync_en),
    .send_en_o  (send_en),
    .recv_en_o  (recv_en),
    .core_en_o  (core_en),
    .sync_err_o (sync_err),
    .core_err_o (core_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: count strobes inside the window
  always @(negedge clk) begin
    if (win) begin
      if (!win_prev) foreach (cnt[k]) cnt[k] = 0;
      cnt[0] += int'(sync_en);
      cnt[1] += int'(send_en);
      cnt[2] += int'(recv_en);
      cnt[3] += int'(core_en);
    end
    win_prev = win;
  end

  // scoreboard compare
  initial forever begin
    @(win_done);
    while (exp_q.size() > 0) begin
      automatic int    e = exp_q.pop_front();
      automatic int    k = kind_q.pop_front();
      automatic string r = req_q.pop_front();
      chk(r, cnt[k], e);
    end
  end

  function automatic int half_div(input logic [2:0] c);
    case (c)
      3'b001:  return 2;
      3'b010:  return 3;
      3'b011:  return 4;
      default: return 6;
    endcase
  endfunction

  task automatic push(input int kind, input int e, input string r);
    exp_q.push_back(e);
    kind_q.push_back(kind);
    req_q.push_back(r);
  endtask

  task automatic cfg(input logic d, input logic [2:0] s, input logic [2:0] p, input logic [2:0] c);
    @(posedge clk); #1;
    dbl = d; s_code = s; p_code = p; c_code = c;
    repeat (200) @(posedge clk);
    #1;
  endtask

  task automatic window(input int len);
    win = 1'b1;
    repeat (len) @(posedge clk);
    #1 win = 1'b0;
    -> win_done;
    #1;
  endtask

  task automatic run_rate(input logic d, input logic [2:0] s, input logic [2:0] p,
                          input logic [2:0] c, input string r);
    int m, ds, dc, per, len;
    cfg(d, s, p, c);
    m   = d ? 1 : 2;
    ds  = half_div(s);
    dc  = half_div(c);
    per = 4 + int'(p);
    len = 6 * ds * dc * per;
    push(0, 2 * len / (m * ds), {r, " sync"});
    push(1, 2 * len / (m * ds * per), "R3 send");
    push(2, 2 * len / (m * ds * per), "R6 recv");
    push(3, 2 * len / (m * dc), "R4 core");
    window(len);
  endtask

  task automatic wait_pulse(input int which, output int t);
    logic hit;
    do begin
      @(negedge clk);
      case (which)
        0:       hit = sync_en;
        1:       hit = send_en;
        default: hit = recv_en;
      endcase
    end while (!hit);
    t = cyc;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, t2, g, gp;
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 en", int'({sync_en, send_en, recv_en, core_en}), 0);
    chk("R9 err", int'({sync_err, core_err}), 0);
    @(posedge clk); #1 rst_ni = 1'b1;

    // R1/R3/R4 rate windows, doubler off
    run_rate(1'b0, 3'b001, 3'b000, 3'b100, "R1 /1");
    run_rate(1'b0, 3'b010, 3'b011, 3'b010, "R1 /1.5");
    run_rate(1'b0, 3'b011, 3'b111, 3'b011, "R1 /2");
    run_rate(1'b0, 3'b100, 3'b101, 3'b000, "R1 /3");
    run_rate(1'b0, 3'b000, 3'b001, 3'b100, "R1 code0");
    run_rate(1'b0, 3'b110, 3'b100, 3'b111, "R1 code6");
    // R5 doubler on
    run_rate(1'b1, 3'b010, 3'b000, 3'b100, "R5 dbl /1.5");
    run_rate(1'b1, 3'b011, 3'b110, 3'b000, "R5 dbl /2");
    run_rate(1'b1, 3'b100, 3'b010, 3'b100, "R5 dbl /3");

    // R2: 1.5 ratio gap pattern
    cfg(1'b1, 3'b010, 3'b000, 3'b100);
    wait_pulse(0, t0);
    gp = 0;
    for (int i = 0; i < 6; i++) begin
      wait_pulse(0, t1);
      g = t1 - t0;
      chk("R2 gap", int'(g == 1 || g == 2), 1);
      if (i > 0) chk("R2 pair", gp + g, 3);
      gp = g;
      t0 = t1;
    end

    // R6: strobe position and width, P=5, sync every 4 clk
    cfg(1'b0, 3'b011, 3'b001, 3'b100);
    wait_pulse(1, t0);
    @(negedge clk);
    chk("R6 send width", int'(send_en), 0);
    wait_pulse(2, t1);
    chk("R6 send->recv", t1 - t0, 8);
    @(negedge clk);
    chk("R6 recv width", int'(recv_en), 0);
    wait_pulse(1, t2);
    chk("R6 recv->send", t2 - t1, 12);

    // R8: period code change mid period
    cfg(1'b0, 3'b011, 3'b000, 3'b100);
    wait_pulse(1, t0);
    @(posedge clk); #1 p_code = 3'b011;
    wait_pulse(1, t1);
    wait_pulse(1, t2);
    chk("R8 old period", t1 - t0, 16);
    chk("R8 new period", t2 - t1, 28);

    // R8: prescaler code change between enables
    wait_pulse(0, t0);
    @(posedge clk); #1 s_code = 3'b100;
    wait_pulse(0, t1);
    wait_pulse(0, t2);
    chk("R8 old prescale", t1 - t0, 4);
    chk("R8 new prescale", t2 - t1, 6);

    // R7: core rate violation, sticky
    @(posedge clk); #1;
    dbl = 1'b1; s_code = 3'b011; c_code = 3'b011;
    repeat (3) @(posedge clk); #1;
    chk("R7 core_err", int'(core_err), 1);
    chk("R7 sync_err clear", int'(sync_err), 0);
    for (int k = 0; k < 4; k++) push(k, 0, "R7 halted");
    window(600);
    dbl = 1'b0; c_code = 3'b100;
    repeat (3) @(posedge clk); #1;
    chk("R7 sticky", int'(core_err), 1);
    for (int k = 0; k < 4; k++) push(k, 0, "R7 still halted");
    window(600);

    // R9: reset clears flags
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 en in reset", int'({sync_en, send_en, recv_en, core_en}), 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R9 err cleared", int'({sync_err, core_err}), 0);

    // R7: synchronous rate violation
    dbl = 1'b1; s_code = 3'b001; c_code = 3'b100;
    repeat (3) @(posedge clk); #1;
    chk("R7 sync_err", int'(sync_err), 1);
    chk("R7 core_err clear", int'(core_err), 0);
    for (int k = 0; k < 4; k++) push(k, 0, "R7 sync halted");
    window(300);

    rst_ni = 1'b0;
    dbl = 1'b0; s_code = 3'b100;
    repeat (2) @(posedge clk); #1 rst_ni = 1'b1;
    repeat (5) @(posedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule